// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This block is the arithmetic and logic stage of a small 16-bit processor. Each operation reads a destination operand and a second operand, and returns a result to be written back into the destination register. The second operand is either a register value or an immediate taken from an extension word. The supported operations are add, subtract, AND, OR, NOR, logical shift left, logical shift right and compare. The result is combinational. A strobe qualifies each operation.

An 8-bit status register is updated on the clock edge of each strobed operation. It holds carry, overflow, negative, zero, interrupt-enable and less-than flags. Conditional branches use the less-than flag. Compare updates the flags like subtract, but it never asks for a write-back. The interrupt-enable flag changes only through its own write port.

Top module: `alu_status_unit`

## Requirements
- R1: Operation codes on `op_sel` are ADD=0, SUB=1, AND=2, OR=3, NOR=4, SHL=5, SHR=6, CMP=7. ADD gives `result` = rd + b modulo 2^16. After the clock edge, c (bit 0) holds the carry out and o (bit 1) holds the signed overflow.
- R2: SUB gives `result` = rd - b modulo 2^16. c is set to the borrow, which is 1 when rd < b unsigned. o is set to the signed overflow of the difference.
- R3: AND, OR and NOR give rd&b, rd|b and ~(rd|b). Each of them clears c and o.
- R4: SHL and SHR shift rd logically with zero fill. The count is the whole of `imm_val`, whatever `use_imm` is. A count of 16 or more gives zero. Both shifts clear c and o.
- R5: Every strobed operation sets n (bit 2) to bit 15 of `result` and z (bit 3) to (`result` == 0). For CMP, `result` carries the difference.
- R6: SUB and CMP set l (bit 5) to the signed comparison rd < b. All other operations leave l unchanged.
- R7: CMP drives `result_we` low and updates c, o, n, z and l exactly as SUB would.
- R8: The second operand b is `imm_val` when `use_imm` is 1 and `rs_val` otherwise.
- R9: Status bits 7:6 always read zero. Reset (`rst_n` low) clears the whole status register to 0x00.
- R10: i (bit 4) loads `ie_val` on a clock edge where `ie_wr` is 1, and no operation changes it.
- R11: With `op_valid` low, `result_we` is 0 and c, o, n, z and l keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the status register |
| op_valid | input | 1 | Strobe: the operation on `op_sel` executes this cycle |
| op_sel | input | 3 | Operation code |
| use_imm | input | 1 | Select the immediate as second operand |
| rd_val | input | 16 | Destination register operand |
| rs_val | input | 16 | Source register operand |
| imm_val | input | 16 | Immediate from the extension word, also the shift count |
| ie_wr | input | 1 | Write strobe for the interrupt-enable flag |
| ie_val | input | 1 | Value for the interrupt-enable flag |
| result | output | 16 | Combinational result |
| result_we | output | 1 | Request to write `result` back to the destination register |
| status | output | 8 | Registered status flags |

## Verification
The bench builds the block with the default width of 16, which is the only width the flag encodings and the table values are written for. At this width the sign boundary 0x7FFF/0x8000 is reached by a single increment. That covers overflow in both directions and the signed less-than cases where the unsigned and signed orders disagree. A 16-bit count also lets the shift tests cover counts of 15, 16 and 256, so the full-count limit and the upper count bits are both exercised.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_NOR = 3'd4,
        OP_SHL = 3'd5,
        OP_SHR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    localparam int SR_WIDTH = 8;
    localparam int SR_C = 0;
    localparam int SR_O = 1;
    localparam int SR_N = 2;
    localparam int SR_Z = 3;
    localparam int SR_I = 4;
    localparam int SR_L = 5;

    // packed MSB first: lt sits at bit 5, cy at bit 0
    typedef struct packed {
        logic lt;
        logic ie;
        logic zr;
        logic ng;
        logic ov;
        logic cy;
    } flags_t;

    localparam int FLAG_BITS = $bits(flags_t);
    localparam int PAD_BITS  = SR_WIDTH - FLAG_BITS;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_NOR = 2'd2
    } bitwise_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub_en,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    always_comb begin
        b_eff     = sub_en ? ~b_in : b_in;
        full      = {1'b0, a_in} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_en};
        sum_out   = full[WIDTH-1:0];
        carry_out = full[WIDTH];
        ovf_out   = (a_in[MSB] == b_eff[MSB]) && (full[MSB] != a_in[MSB]);
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]            a_in,
    input  logic [WIDTH-1:0]            b_in,
    input  alu_flags_pkg::bitwise_e     fn,
    output logic [WIDTH-1:0]            y_out
);
    import alu_flags_pkg::*;

    always_comb begin
        unique case (fn)
            BW_AND:  y_out = a_in & b_in;
            BW_OR:   y_out = a_in | b_in;
            BW_NOR:  y_out = ~(a_in | b_in);
            default: y_out = '0;
        endcase
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [WIDTH-1:0] count,
    input  logic             to_left,
    output logic [WIDTH-1:0] data_out
);
    localparam int STAGES = $clog2(WIDTH);

    logic [WIDTH-1:0] stg [STAGES+1];
    logic             too_far;

    assign stg[0]  = data_in;
    assign too_far = |count[WIDTH-1:STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stg[k+1] = count[k] ? (to_left ? (stg[k] << DIST) : (stg[k] >> DIST))
                                   : stg[k];
    end

    assign data_out = too_far ? '0 : stg[STAGES];

    // one-place shift must match a plain concatenation
    always_comb begin
        if (count == WIDTH'(1) && to_left)
            assert_shl_by_one_R4: assert (data_out == {data_in[WIDTH-2:0], 1'b0});
        if (count == WIDTH'(1) && !to_left)
            assert_shr_by_one_R4: assert (data_out == {1'b0, data_in[WIDTH-1:1]});
    end

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_sel,
    input  logic             use_imm,
    input  logic [WIDTH-1:0] rd_val,
    input  logic [WIDTH-1:0] rs_val,
    input  logic [WIDTH-1:0] imm_val,
    input  logic             ie_wr,
    input  logic             ie_val,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic [7:0]       status
);
    import alu_flags_pkg::*;

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        flags_t flg;
    } state_t;

    state_t st_d, st_q;

    alu_op_e          op;
    logic [WIDTH-1:0] opnd_b;
    logic             is_diff;
    logic             is_logic;
    logic [WIDTH-1:0] as_sum;
    logic             as_carry;
    logic             as_ovf;
    logic [WIDTH-1:0] bw_y;
    logic [WIDTH-1:0] sh_y;
    bitwise_e         bw_fn;

    assign op       = alu_op_e'(op_sel);
    assign opnd_b   = use_imm ? imm_val : rs_val;
    assign is_diff  = (op == OP_SUB) || (op == OP_CMP);
    assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_NOR) ||
                      (op == OP_SHL) || (op == OP_SHR);

    always_comb begin
        unique case (op)
            OP_OR:   bw_fn = BW_OR;
            OP_NOR:  bw_fn = BW_NOR;
            default: bw_fn = BW_AND;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_in      (rd_val),
        .b_in      (opnd_b),
        .sub_en    (is_diff),
        .sum_out   (as_sum),
        .carry_out (as_carry),
        .ovf_out   (as_ovf)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_in  (rd_val),
        .b_in  (opnd_b),
        .fn    (bw_fn),
        .y_out (bw_y)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shifter (
        .data_in  (rd_val),
        .count    (imm_val),
        .to_left  (op == OP_SHL),
        .data_out (sh_y)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_CMP: result = as_sum;
            OP_AND, OP_OR, OP_NOR:  result = bw_y;
            OP_SHL, OP_SHR:         result = sh_y;
            default:                result = '0;
        endcase
        result_we = op_valid && (op != OP_CMP);
    end

    // next-state computation
    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            st_d.flg.ng = result[MSB];
            st_d.flg.zr = (result == '0);
            if (is_logic) begin
                st_d.flg.cy = 1'b0;
                st_d.flg.ov = 1'b0;
            end else begin
                st_d.flg.cy = is_diff ? ~as_carry : as_carry;
                st_d.flg.ov = as_ovf;
            end
            if (is_diff)
                st_d.flg.lt = as_sum[MSB] ^ as_ovf;
        end
        if (ie_wr)
            st_d.flg.ie = ie_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = {{PAD_BITS{1'b0}}, st_q.flg};

    // checks
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !ie_wr) |=> $stable(status));

    assert_no_we_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !result_we);

    assert_cmp_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd7) |-> !result_we);

    assert_add_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd0) |-> (result == WIDTH'(rd_val + opnd_b)));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (status[SR_Z] == ($past(result) == '0)));

    assert_neg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (status[SR_N] == $past(result[MSB])));

    assert_lt_signed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 3'd1 || op_sel == 3'd7)) |=>
        (status[SR_L] == ($signed($past(rd_val)) < $signed($past(opnd_b)))));

    assert_lt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel != 3'd1 && op_sel != 3'd7) |=> $stable(status[SR_L]));

    assert_logic_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel >= 3'd2 && op_sel <= 3'd6) |=> (status[SR_O:SR_C] == 2'b00));

    assert_ie_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_wr |=> $stable(status[SR_I]));

    assert_ie_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ie_wr |=> (status[SR_I] == $past(ie_val)));

endmodule

// File: tb/alu_status_unit_bench.sv
`timescale 1ns/1ps
module alu_status_unit_bench;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_sel = 3'd0;
    logic          use_imm = 1'b0;
    logic [W-1:0]  rd_val = '0;
    logic [W-1:0]  rs_val = '0;
    logic [W-1:0]  imm_val = '0;
    logic          ie_wr = 1'b0;
    logic          ie_val = 1'b0;
    logic [W-1:0]  result;
    logic          result_we;
    logic [7:0]    status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    alu_status_unit #(.WIDTH(W)) u_alu_status_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .use_imm(use_imm), .rd_val(rd_val), .rs_val(rs_val), .imm_val(imm_val),
        .ie_wr(ie_wr), .ie_val(ie_val), .result(result), .result_we(result_we),
        .status(status)
    );

    // flg = {l, z, n, o, c}; l only meaningful for SUB (1) and CMP (7)
    typedef struct packed {
        logic [2:0]   op;
        logic         imm_sel;
        logic [15:0]  rd;
        logic [15:0]  rs;
        logic [15:0]  imm;
        logic [15:0]  res;
        logic [4:0]   flg;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 1'b0, 16'h0001, 16'h0002, 16'h0000, 16'h0003, 5'b00000}, // R1 plain add
        '{3'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0000, 5'b01001}, // R1 carry
        '{3'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h0000, 16'h8000, 5'b00110}, // R1 overflow
        '{3'd0, 1'b1, 16'h8000, 16'h1234, 16'h8000, 16'h0000, 5'b01011}, // R8 imm add
        '{3'd1, 1'b0, 16'h0005, 16'h0003, 16'h0000, 16'h0002, 5'b00000}, // R2
        '{3'd1, 1'b0, 16'h0003, 16'h0005, 16'h0000, 16'hFFFE, 5'b10101}, // R2 borrow
        '{3'd1, 1'b0, 16'h8000, 16'h0001, 16'h0000, 16'h7FFF, 5'b10010}, // R2 overflow
        '{3'd1, 1'b1, 16'h0010, 16'hFFFF, 16'h0010, 16'h0000, 5'b01000}, // R8 imm sub
        '{3'd7, 1'b0, 16'hFFFE, 16'h0001, 16'h0000, 16'hFFFD, 5'b10100}, // R7 cmp lt
        '{3'd2, 1'b0, 16'hF0F0, 16'h0FF0, 16'h0000, 16'h00F0, 5'b00000}, // R3 and, l held
        '{3'd3, 1'b1, 16'h8000, 16'h0000, 16'h0001, 16'h8001, 5'b00100}, // R3 or imm
        '{3'd4, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 5'b00100}, // R3 nor
        '{3'd4, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 5'b01000}, // R3 nor zero
        '{3'd5, 1'b0, 16'h0001, 16'h0003, 16'h000F, 16'h8000, 5'b00100}, // R4 shl 15
        '{3'd6, 1'b0, 16'h8000, 16'h0000, 16'h000F, 16'h0001, 5'b00000}, // R4 shr 15
        '{3'd5, 1'b0, 16'hFFFF, 16'h0000, 16'h0010, 16'h0000, 5'b01000}, // R4 shl 16
        '{3'd6, 1'b1, 16'hFFFF, 16'h0000, 16'h0100, 16'h0000, 5'b01000}, // R4 shr 256
        '{3'd6, 1'b0, 16'h8000, 16'h0000, 16'h0000, 16'h8000, 5'b00100}, // R4 shr 0
        '{3'd7, 1'b0, 16'h0001, 16'h0001, 16'h0000, 16'h0000, 5'b01000}, // R7 cmp equal
        '{3'd7, 1'b0, 16'h0001, 16'hFFFF, 16'h0000, 16'h0002, 5'b00001}, // R6 unsigned vs signed
        '{3'd7, 1'b0, 16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF, 5'b00111}, // R6 cmp overflow
        '{3'd5, 1'b0, 16'h00FF, 16'h0000, 16'h0008, 16'hFF00, 5'b00100}  // R6 l held 0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] op, input logic im,
                         input logic [15:0] rd, input logic [15:0] rs,
                         input logic [15:0] imm, input logic iw, input logic iv);
        op_valid = v; op_sel = op; use_imm = im;
        rd_val = rd; rs_val = rs; imm_val = imm;
        ie_wr = iw; ie_val = iv;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic model_l;
        logic model_i;
        logic [7:0] keep;

        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset status", status, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: set interrupt enable with no operation
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b1);
        @(posedge clk); #1;
        chk("R10 ie write", status, 8'h10);
        model_i = 1'b1;
        model_l = 1'b0;

        // table walk; every op keeps i at 1 (R10) and bits 7:6 at zero (R9)
        for (int i = 0; i < NV; i++) begin
            logic lt;
            @(negedge clk);
            drive(1'b1, TBL[i].op, TBL[i].imm_sel, TBL[i].rd, TBL[i].rs, TBL[i].imm, 1'b0, 1'b0);
            #1;
            chk($sformatf("R1-table result %0d", i), result, TBL[i].res);
            chk($sformatf("R7 result_we %0d", i), result_we, (TBL[i].op != 3'd7));
            @(posedge clk); #1;
            lt = (TBL[i].op == 3'd1 || TBL[i].op == 3'd7) ? TBL[i].flg[4] : model_l;
            model_l = lt;
            chk($sformatf("R5 status %0d", i), status,
                {2'b00, lt, model_i, TBL[i].flg[3], TBL[i].flg[2], TBL[i].flg[1], TBL[i].flg[0]});
        end

        // R11: idle cycles with changing inputs leave the flags alone
        @(negedge clk);
        keep = status;
        drive(1'b0, 3'd1, 1'b0, 16'h0000, 16'h0001, 16'h0000, 1'b0, 1'b0);
        #1;
        chk("R11 no write when idle", result_we, 1'b0);
        @(posedge clk); #1;
        chk("R11 hold status", status, keep);
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b0, 1'b0);
        @(posedge clk); #1;
        chk("R11 hold status again", status, keep);

        // R10: ie cleared together with an add producing zero and carry
        @(negedge clk);
        drive(1'b1, 3'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0);
        @(posedge clk); #1;
        chk("R10 ie clear with op", status, {2'b00, model_l, 1'b0, 4'b1001});

        // R9: reset mid-run clears flags
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b1);
        @(posedge clk); #1;
        chk("R10 ie set before reset", status[4], 1'b1);
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R9 reset clears", status, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule